// File: doc/BRIEF.md
# Global Timer Register Bank

This block holds the registers of four countdown timers that feed a shared interrupt controller, together with a small bank of per-CPU timer frequency words. A register port with one request per cycle carries 32-bit reads and writes. Each timer has four words: a current count, a base count, a vector/priority word and a destination word. Bit 31 of the base count is an inhibit flag. Bit 31 of the current count is a toggle that flips on every reload.

While a timer is not inhibited, it steps down once for each cycle in which `tick_en` is high. When its count field is already zero on a tick, it reloads from the base count and emits a one-cycle request on its `irq_pulse` line, unless bit 31 of its vector/priority word (the mask) is set. Prioritisation and delivery to CPUs happen downstream.

The request port has no back-pressure. A request is accepted in every cycle in which `req_valid` is high. A read returns its data with `rsp_valid` exactly one cycle later, and a write produces no response.

Top module: `gtmr_bank`

## Requirements
- R1: Reset sets, for every timer, current count 0x00000000, base count 0x80000000, vector/priority 0x80800000 and destination 0x00000001. Every frequency word resets to 0, and `irq_pulse` and `rsp_valid` are low.
- R2: A request whose address bits 3:0 are not all zero is ignored. A read of such an address returns 0xFFFFFFFF, and a write changes no register.
- R3: For an aligned address whose low byte is not 0xF0, bits 7:6 select the timer and bits 5:4 select the word: 0 is count, 1 is base, 2 is vector/priority, 3 is destination. Address bits 15:8 are ignored for timer words.
- R4: An aligned address whose low byte is 0xF0 selects the frequency word of CPU `addr[15:12]`. If that index is not below NUM_CPU, a write is ignored and a read returns 0xFFFFFFFF.
- R5: The current count word is read-only: a write to it leaves the count unchanged.
- R6: A base write clears count bit 31 only when count bit 31 is 1, the stored base bit 31 is 1 and the written bit 31 is 0. In every case the written value is stored as the new base.
- R7: While base bit 31 is 0, on each `tick_en` cycle a timer does one of two things. If count bits 30:0 are zero, it loads them from base bits 30:0 and inverts count bit 31; otherwise it decrements them by one. While base bit 31 is 1, the count holds.
- R8: A reload (R7) drives that timer's `irq_pulse` bit high for the single cycle after the tick edge, unless vector/priority bit 31 was set at the tick. Without a reload the bit stays low.
- R9: `rsp_valid` is high in exactly the cycle after each read request and carries the read data in `rsp_rdata`. It is low after writes and after idle cycles.
- R10: Writes to the base, vector/priority and destination words store and read back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one step per high cycle |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset within the timer window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_pulse | output | 4 | Per-timer one-cycle interrupt request |

## Verification
The properties assume that `req_write`, `req_addr` and `tick_en` are known, 0 or 1 on every bit, whenever reset is released. They also assume that a read request is never held across two cycles with the intent of getting a single response. The stimulus meets both assumptions: it drives every input from one task at the falling edge, drops `req_valid` after one cycle, and leaves an idle cycle between requests. Ticks are issued one at a time, with register traffic in between. This lets each interrupt request be tied to the tick that caused it.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int TMR_CNT   = 4;
  localparam int TMR_IDX_W = $clog2(TMR_CNT);
  localparam int CPU_IDX_W = 4;
  localparam int TOP_BIT   = DATA_W - 1;

  localparam logic [DATA_W-1:0] RST_COUNT  = 32'h0000_0000;
  localparam logic [DATA_W-1:0] RST_BASE   = 32'h8000_0000;
  localparam logic [DATA_W-1:0] RST_VECPRI = 32'h8080_0000;
  localparam logic [DATA_W-1:0] RST_DEST   = 32'h0000_0001;
  localparam logic [DATA_W-1:0] RD_MISS    = '1;
  localparam logic [7:0]        FREQ_SLOT  = 8'hF0;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_BASE   = 2'd1,
    REG_VECPRI = 2'd2,
    REG_DEST   = 2'd3
  } tmr_reg_e;

  typedef struct packed {
    logic                 hit_tmr;
    logic                 hit_freq;
    logic [TMR_IDX_W-1:0] tmr;
    tmr_reg_e             rsel;
    logic [CPU_IDX_W-1:0] cpu;
  } dec_t;
endpackage

// File: rtl/gtmr_decode.sv
module gtmr_decode
  import gtmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [CPU_IDX_W:0] CPU_LIM = (CPU_IDX_W+1)'(NUM_CPU);

  logic aligned;
  logic freq_slot;

  always_comb begin
    aligned      = (addr[3:0] == 4'h0);
    freq_slot    = (addr[7:0] == FREQ_SLOT);
    dec.cpu      = addr[15:12];
    dec.tmr      = addr[7:6];
    dec.rsel     = tmr_reg_e'(addr[5:4]);
    dec.hit_freq = aligned && freq_slot && ({1'b0, addr[15:12]} < CPU_LIM);
    dec.hit_tmr  = aligned && !freq_slot;
  end
endmodule

// File: rtl/gtmr_timer.sv
module gtmr_timer
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_base,
  input  logic              wr_vecpri,
  input  logic              wr_dest,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] vecpri,
  output logic [DATA_W-1:0] dest,
  output logic              irq
);
  logic              inhibit;
  logic              at_zero;
  logic              expire;
  logic [DATA_W-1:0] count_d;

  assign inhibit = base[TOP_BIT];
  assign at_zero = (count[TOP_BIT-1:0] == '0);
  assign expire  = tick_en && !inhibit && at_zero;

  always_comb begin
    count_d = count;
    if (tick_en && !inhibit) begin
      if (at_zero) count_d = {~count[TOP_BIT], base[TOP_BIT-1:0]};
      else         count_d = {count[TOP_BIT], count[TOP_BIT-1:0] - 1'b1};
    end
    // toggle bit is cleared only on a 1->0 inhibit write while it is set
    if (wr_base && count[TOP_BIT] && inhibit && !wdata[TOP_BIT])
      count_d[TOP_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= RST_COUNT;
      base   <= RST_BASE;
      vecpri <= RST_VECPRI;
      dest   <= RST_DEST;
      irq    <= 1'b0;
    end else begin
      count <= count_d;
      if (wr_base)   base   <= wdata;
      if (wr_vecpri) vecpri <= wdata;
      if (wr_dest)   dest   <= wdata;
      irq <= expire && !vecpri[TOP_BIT];
    end
  end
endmodule

// File: rtl/gtmr_freq_bank.sv
module gtmr_freq_bank
  import gtmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CPU_IDX_W-1:0] cpu,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] regs [NUM_CPU];

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n)                                regs[g] <= '0;
      else if (wr_en && cpu == CPU_IDX_W'(g))    regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = RD_MISS;
    for (int i = 0; i < NUM_CPU; i++)
      if (cpu == CPU_IDX_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/gtmr_bank.sv
module gtmr_bank
  import gtmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [3:0]        irq_pulse
);
  dec_t              dec;
  logic              wr_req;
  logic              rd_req;
  logic [DATA_W-1:0] cnt_a  [TMR_CNT];
  logic [DATA_W-1:0] base_a [TMR_CNT];
  logic [DATA_W-1:0] vp_a   [TMR_CNT];
  logic [DATA_W-1:0] dst_a  [TMR_CNT];
  logic [TMR_CNT-1:0] mask_vec;
  logic [TMR_CNT-1:0] inhib_vec;
  logic [DATA_W-1:0] freq_rd;
  logic [DATA_W-1:0] rd_word;

  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  gtmr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  for (genvar g = 0; g < TMR_CNT; g++) begin : g_tmr
    logic sel;
    assign sel = wr_req && dec.hit_tmr && (dec.tmr == TMR_IDX_W'(g));

    gtmr_timer u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .wr_base   (sel && dec.rsel == REG_BASE),
      .wr_vecpri (sel && dec.rsel == REG_VECPRI),
      .wr_dest   (sel && dec.rsel == REG_DEST),
      .wdata     (req_wdata),
      .count     (cnt_a[g]),
      .base      (base_a[g]),
      .vecpri    (vp_a[g]),
      .dest      (dst_a[g]),
      .irq       (irq_pulse[g])
    );

    assign mask_vec[g]  = vp_a[g][TOP_BIT];
    assign inhib_vec[g] = base_a[g][TOP_BIT];
  end

  gtmr_freq_bank #(.NUM_CPU(NUM_CPU)) u_freq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_req && dec.hit_freq),
    .cpu   (dec.cpu),
    .wdata (req_wdata),
    .rdata (freq_rd)
  );

  always_comb begin
    rd_word = RD_MISS;
    if (dec.hit_freq) begin
      rd_word = freq_rd;
    end else if (dec.hit_tmr) begin
      unique case (dec.rsel)
        REG_COUNT:  rd_word = cnt_a[dec.tmr];
        REG_BASE:   rd_word = base_a[dec.tmr];
        REG_VECPRI: rd_word = vp_a[dec.tmr];
        REG_DEST:   rd_word = dst_a[dec.tmr];
        default:    rd_word = RD_MISS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/gtmr_bank_chk.sv
module gtmr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        req_valid,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [3:0]  irq_pulse,
  input logic [3:0]  mask_vec,
  input logic [3:0]  inhib_vec
);
  // R9
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R9
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R2
  misaligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[3:0] != 4'h0) |=> (rsp_rdata == 32'hFFFF_FFFF));

  // R8
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> $past(tick_en));

  // R8
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> ((irq_pulse & $past(mask_vec)) == 4'h0));

  // R7
  inhibited_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> ((irq_pulse & $past(inhib_vec)) == 4'h0));
endmodule

bind gtmr_bank gtmr_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .irq_pulse (irq_pulse),
  .mask_vec  (mask_vec),
  .inhib_vec (inhib_vec)
);

// File: tb/gtmr_bank_tb.sv
`timescale 1ns/1ps
module gtmr_bank_tb;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  irq_pulse;

  always #2.5 clk = ~clk;

  gtmr_bank #(.NUM_CPU(NCPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_pulse(irq_pulse)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] m_cnt  [4];
  logic [31:0] m_base [4];
  logic [31:0] m_vp   [4];
  logic [31:0] m_dst  [4];
  logic [31:0] m_freq [NCPU];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    int t, c;
    if (a[3:0] != 4'h0) return 32'hFFFF_FFFF;
    if (a[7:0] == 8'hF0) begin
      c = int'(a[15:12]);
      return (c < NCPU) ? m_freq[c] : 32'hFFFF_FFFF;
    end
    t = int'(a[7:6]);
    case (a[5:4])
      2'd0: return m_cnt[t];
      2'd1: return m_base[t];
      2'd2: return m_vp[t];
      default: return m_dst[t];
    endcase
  endfunction

  task automatic model_wr(logic [15:0] a, logic [31:0] d);
    int t, c;
    if (a[3:0] != 4'h0) return;
    if (a[7:0] == 8'hF0) begin
      c = int'(a[15:12]);
      if (c < NCPU) m_freq[c] = d;
      return;
    end
    t = int'(a[7:6]);
    case (a[5:4])
      2'd1: begin
        if (m_cnt[t][31] && m_base[t][31] && !d[31]) m_cnt[t][31] = 1'b0;
        m_base[t] = d;
      end
      2'd2: m_vp[t] = d;
      2'd3: m_dst[t] = d;
      default: ;
    endcase
  endtask

  task automatic do_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_wr(a, d);
    chk("R9 no response to write", 32'(rsp_valid), 32'd0);
  endtask

  task automatic do_rd(string tag, logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 read valid", 32'(rsp_valid), 32'd1);
    chk(tag, rsp_rdata, exp_rd(a));
  endtask

  task automatic do_tick();
    logic [3:0] e;
    e = 4'h0;
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (!m_base[i][31]) begin
        if (m_cnt[i][30:0] == 31'd0) begin
          e[i] = !m_vp[i][31];
          m_cnt[i] = {~m_cnt[i][31], m_base[i][30:0]};
        end else begin
          m_cnt[i][30:0] = m_cnt[i][30:0] - 31'd1;
        end
      end
    end
    @(negedge clk);
    tick_en = 1'b0;
    chk("R8 irq pulse", 32'(irq_pulse), 32'(e));
  endtask

  task automatic read_counts(string tag);
    for (int t = 0; t < 4; t++) do_rd(tag, 16'(t << 6));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 32'h0000_0000; m_base[i] = 32'h8000_0000;
      m_vp[i]  = 32'h8080_0000; m_dst[i]  = 32'h0000_0001;
    end
    for (int c = 0; c < NCPU; c++) m_freq[c] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents of every word
    chk("R1 irq idle", 32'(irq_pulse), 32'd0);
    chk("R1 rsp idle", 32'(rsp_valid), 32'd0);
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) do_rd("R1 timer reset", 16'((t << 6) | (r << 4)));
    for (int c = 0; c < NCPU; c++) do_rd("R1 freq reset", 16'((c << 12) | 8'hF0));

    // R3 / R10: write through aliased pages, read back at page 0
    for (int t = 0; t < 4; t++) begin
      do_wr(16'((t << 12) | ((t + 1) << 8) | (t << 6) | 16'h10), 32'h8000_0000 | 32'(t << 8) | 32'h55);
      do_wr(16'((t << 12) | ((t + 1) << 8) | (t << 6) | 16'h20), 32'h8000_1000 + 32'(t));
      do_wr(16'((t << 12) | ((t + 1) << 8) | (t << 6) | 16'h30), 32'hA5A5_0000 | 32'(1 << t));
    end
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) do_rd("R3 R10 decode readback", 16'((t << 6) | (r << 4)));

    // R5: count is read-only
    for (int t = 0; t < 4; t++) do_wr(16'(t << 6), 32'h1234_5678);
    read_counts("R5 count read-only");

    // R2: misaligned reads and an ignored misaligned write
    for (int off = 1; off < 16; off++) do_rd("R2 misaligned read", 16'(16'h50 + off));
    do_wr(16'h54, 32'h0000_0000);
    do_rd("R2 misaligned write ignored", 16'h50);

    // R4: frequency words and out-of-range CPU index
    for (int c = 0; c < NCPU; c++) do_wr(16'((c << 12) | 8'hF0), 32'h1000 + 32'(c * 7));
    do_wr(16'h50F0, 32'hDEAD_BEEF);
    for (int c = 0; c < NCPU; c++) do_rd("R4 freq readback", 16'((c << 12) | 8'hF0));
    do_rd("R4 cpu out of range", 16'h40F0);
    do_rd("R4 cpu out of range", 16'h90F0);
    do_rd("R4 cpu out of range", 16'hF0F0);

    // R9: response lasts one cycle only
    do_rd("R9 read", 16'h0020);
    @(negedge clk);
    chk("R9 single cycle", 32'(rsp_valid), 32'd0);

    // R7 / R8: timer 0 unmasked, timer 2 masked, both running
    do_wr(16'h0020, 32'h0000_0000);
    do_wr(16'h0010, 32'h0000_0003);
    do_wr(16'h0090, 32'h0000_0002);
    for (int k = 0; k < 10; k++) begin
      do_tick();
      read_counts("R7 countdown");
    end

    // R6: inhibit toggle-bit rule, timer 0
    for (int k = 0; k < 8 && !m_cnt[0][31]; k++) do_tick();
    chk("R6 precondition toggle set", 32'(m_cnt[0][31]), 32'd1);
    do_wr(16'h0010, 32'h8000_0003);
    do_rd("R6 inhibit set keeps toggle", 16'h0000);
    do_tick();
    do_rd("R7 inhibited holds", 16'h0000);
    do_wr(16'h0010, 32'h8000_0005);
    do_rd("R6 inhibit stays keeps toggle", 16'h0000);
    do_wr(16'h0010, 32'h0000_0005);
    do_rd("R6 inhibit cleared clears toggle", 16'h0000);
    do_rd("R6 base stored", 16'h0010);
    for (int k = 0; k < 8; k++) begin
      do_tick();
      read_counts("R7 restart");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule